// File: doc/BRIEF.md
# Serial-Bus Physical-Layer Register Bank

This block is the register bank of a serial-bus physical layer. The link controller reaches it through a single access port that carries a 4-bit address and 8-bit data. The bank holds three kinds of field. Read-only status fields report the node address, the root flag, the connection state, the cable-power level and the two line states. Read/write configuration fields hold the gap count, the root-holdoff request and the initiate-bus-reset request. Sticky interrupt flags cover cable-power loss and configuration-loop timeout.

Arbitration, tree identification and self-identification happen elsewhere. They reach this block only as single-cycle event inputs: a bus reset, self-ID completion with a new address, a root indication, a loop timeout and a gap-count load from a configuration packet. The configuration fields leave the block as plain pins toward the arbiter.

A hardware reset and a bus reset have different effects on the fields. The gap count returns to its default only when two bus resets arrive with no gap update between them. The cable-power interrupt keeps setting for as long as the power input stays low.

The access port takes one access per cycle and never stalls. A read request (`acc_valid` high, `acc_write` low) always returns `rsp_valid` with `rsp_data` exactly one cycle later. The response has no ready signal, so the link must accept it in that cycle. Writes produce no response.

Top module: `sbphy_regbank`

## Requirements
- R1: On hardware reset the fields take these values:
  - gap count 3Fh, root-holdoff 0, initiate-bus-reset 0;
  - node address 09h, root 0, connection 1;
  - both line states 00, both interrupt flags 0.
- R2: A read returns the addressed byte on `rsp_data` with `rsp_valid` high on the cycle after the request.
  - Addresses 5 to 15 read 00h.
  - Address 3 is constant: revision 01 in [7:6], zeros in [5:4], port count 0011 in [3:0], so it reads 43h.
  - Writes to addresses 0, 2 and 3 change nothing.
- R3: Register 1 holds root-holdoff [7], initiate-bus-reset [6] and gap count [5:0].
  - A link write to register 1 loads all three fields.
  - A configuration-packet load (`phycfg_load`) sets the gap count to `phycfg_gap`.
  - If the load and a link write arrive in the same cycle, the load sets the gap count.
- R4: The gap count returns to 3Fh on a bus reset when the previous bus reset has had no gap update after it. A gap update is a link write to register 1 or a `phycfg_load`. A single bus reset leaves the gap count unchanged.
- R5: Initiate-bus-reset is driven out on `start_bus_reset` and clears on a bus reset. A link write to register 1 in the same cycle as a bus reset is dropped as a whole.
- R6: Root-holdoff is driven out on `root_holdoff` and is unchanged by a bus reset.
- R7: Register 0 holds the node address in [7:2].
  - The address reads 09h after a bus reset.
  - On `selfid_done` it takes `selfid_addr`.
  - A bus reset in the same cycle as `selfid_done` wins.
- R8: Register 0 [1] is the root flag. It sets on `root_evt` and clears on a bus reset. The bus reset wins when both arrive in the same cycle.
- R9: Register 2 [3] is the connection flag. It copies `cable_conn` on a bus reset and otherwise holds its value.
- R10: Register 2 shows line state A in [7:6] and line state B in [5:4]. The codes are 11 = Z, 01 = one, 10 = zero, 00 = invalid. The line inputs are registered once, and bits [2:0] read 0.
- R11: The cable-power interrupt, register 4 [6], sets in every cycle that `cps_in` is low.
  - Writing 0 to it clears the flag only while `cps_in` is high.
  - Writing 1 to it has no effect.
  - The registered power level reads at register 4 [5] and register 0 [0].
- R12: The loop interrupt, register 4 [7], sets on `loop_timeout`.
  - A write of 0 clears it.
  - A write of 1 has no effect.
  - A set and a clear in the same cycle leave the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| acc_valid | input | 1 | Access request present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 4 | Register address |
| acc_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle after the read request) |
| rsp_data | output | 8 | Read data |
| bus_rst | input | 1 | Bus-reset event pulse |
| selfid_done | input | 1 | Self-ID complete pulse |
| selfid_addr | input | 6 | New node address, valid with selfid_done |
| root_evt | input | 1 | Node became root during tree-ID |
| loop_timeout | input | 1 | Configuration-loop timeout pulse |
| cps_in | input | 1 | Cable power adequate (1) or low (0) |
| cable_conn | input | 1 | Debounced cable connection status |
| line_a | input | 2 | Line state of cable pair A |
| line_b | input | 2 | Line state of cable pair B |
| phycfg_load | input | 1 | Gap-count load from a configuration packet |
| phycfg_gap | input | 6 | Gap count carried by that packet |
| gap_count | output | 6 | Current gap count to the arbiter |
| root_holdoff | output | 1 | Root-holdoff request to the arbiter |
| start_bus_reset | output | 1 | Initiate-bus-reset request to the arbiter |

## Verification
The hardest case to reach is the gap-count fallback. It depends on a hidden history: whether a gap update has happened since the last bus reset. No single read exposes that history. The stimulus therefore builds explicit event chains and reads register 1 after each link:
- write, then one bus reset, to show the value survives;
- a second bus reset, to show the fallback;
- a bus reset followed by a configuration-packet load, to show that a load also re-arms the count.

Same-cycle collisions are driven deliberately to pin down which source wins:
- bus reset against a link write;
- bus reset against self-ID completion;
- loop timeout against a clearing write;
- cable power still low against a clearing write.

// File: rtl/sbphy_regbank_pkg.sv
package sbphy_regbank_pkg;
  localparam int DW  = 8;
  localparam int IDW = 6;
  localparam int GW  = 6;
  localparam int LSW = 2;
  localparam int NPAIR = 2;

  localparam logic [1:0] REV_CODE   = 2'b01;
  localparam logic [3:0] PORT_COUNT = 4'b0011;

  typedef enum logic [2:0] {
    REG_NODE  = 3'd0,
    REG_CFG   = 3'd1,
    REG_LINE  = 3'd2,
    REG_IDENT = 3'd3,
    REG_IRQ   = 3'd4
  } reg_sel_e;

  typedef struct packed {
    logic          rhb;
    logic          ibr;
    logic [GW-1:0] gap;
  } cfg_t;

  typedef struct packed {
    logic [IDW-1:0]         phys_id;
    logic                   root;
    logic                   conn;
    logic                   cps;
    logic                   cps_irq;
    logic                   loop_irq;
    logic [NPAIR*LSW-1:0]   ls;
  } stat_t;
endpackage

// File: rtl/sbphy_cfg_regs.sv
module sbphy_cfg_regs
  import sbphy_regbank_pkg::*;
#(
  parameter logic [GW-1:0] GAP_RESET = 6'h3F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_rst,
  input  logic          wr_cfg,
  input  logic [DW-1:0] wdata,
  input  logic          phycfg_load,
  input  logic [GW-1:0] phycfg_gap,
  output cfg_t          cfg_q
);
  // armed: a bus reset has been seen with no gap update since
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.rhb <= 1'b0;
      cfg_q.ibr <= 1'b0;
      cfg_q.gap <= GAP_RESET;
      armed     <= 1'b0;
    end else if (bus_rst) begin
      cfg_q.ibr <= 1'b0;
      if (armed) cfg_q.gap <= GAP_RESET;
      armed <= 1'b1;
    end else begin
      if (phycfg_load) begin
        cfg_q.gap <= phycfg_gap;
        armed     <= 1'b0;
      end else if (wr_cfg) begin
        cfg_q.gap <= wdata[GW-1:0];
        armed     <= 1'b0;
      end
      if (wr_cfg) begin
        cfg_q.rhb <= wdata[7];
        cfg_q.ibr <= wdata[6];
      end
    end
  end

  assert_load_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    phycfg_load && !bus_rst |=> cfg_q.gap == $past(phycfg_gap));
  assert_ibr_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> !cfg_q.ibr);
  assert_rhb_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> $stable(cfg_q.rhb));
  assert_single_reset_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    phycfg_load && !bus_rst ##1 bus_rst |=> cfg_q.gap == $past(cfg_q.gap));
endmodule

// File: rtl/sbphy_stat_regs.sv
module sbphy_stat_regs
  import sbphy_regbank_pkg::*;
#(
  parameter logic [IDW-1:0] ID_RESET = 6'h09
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_rst,
  input  logic                 selfid_done,
  input  logic [IDW-1:0]       selfid_addr,
  input  logic                 root_evt,
  input  logic                 loop_timeout,
  input  logic                 cps_in,
  input  logic                 cable_conn,
  input  logic [NPAIR*LSW-1:0] line_in,
  input  logic                 wr_irq,
  input  logic [1:0]           wdata_irq,
  output stat_t                st_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q.phys_id <= ID_RESET;
      st_q.root    <= 1'b0;
      st_q.conn    <= 1'b1;
    end else if (bus_rst) begin
      st_q.phys_id <= ID_RESET;
      st_q.root    <= 1'b0;
      st_q.conn    <= cable_conn;
    end else begin
      if (selfid_done) st_q.phys_id <= selfid_addr;
      if (root_evt)    st_q.root    <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q.cps      <= 1'b0;
      st_q.cps_irq  <= 1'b0;
      st_q.loop_irq <= 1'b0;
    end else begin
      st_q.cps <= cps_in;
      if (!cps_in)                      st_q.cps_irq <= 1'b1;
      else if (wr_irq && !wdata_irq[0]) st_q.cps_irq <= 1'b0;
      if (loop_timeout)                 st_q.loop_irq <= 1'b1;
      else if (wr_irq && !wdata_irq[1]) st_q.loop_irq <= 1'b0;
    end
  end

  for (genvar p = 0; p < NPAIR; p++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q.ls[p*LSW +: LSW] <= '0;
      else        st_q.ls[p*LSW +: LSW] <= line_in[p*LSW +: LSW];
    end
  end

  assert_id_default_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> st_q.phys_id == ID_RESET);
  assert_root_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> !st_q.root);
  assert_conn_sampled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> st_q.conn == $past(cable_conn));
  assert_cps_refire_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cps_in |=> st_q.cps_irq);
  assert_loop_set_R12: assert property (@(posedge clk) disable iff (!rst_n)
    loop_timeout |=> st_q.loop_irq);
endmodule

// File: rtl/sbphy_rd_mux.sv
module sbphy_rd_mux
  import sbphy_regbank_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  cfg_t              cfg,
  input  stat_t             st,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_data
);
  localparam logic [ADDR_W-1:0] A_NODE  = ADDR_W'(REG_NODE);
  localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(REG_CFG);
  localparam logic [ADDR_W-1:0] A_LINE  = ADDR_W'(REG_LINE);
  localparam logic [ADDR_W-1:0] A_IDENT = ADDR_W'(REG_IDENT);
  localparam logic [ADDR_W-1:0] A_IRQ   = ADDR_W'(REG_IRQ);

  logic [DW-1:0] sel;

  always_comb begin
    sel = '0;
    case (acc_addr)
      A_NODE:  sel = {st.phys_id, st.root, st.cps};
      A_CFG:   sel = {cfg.rhb, cfg.ibr, cfg.gap};
      A_LINE:  sel = {st.ls, st.conn, 3'b000};
      A_IDENT: sel = {REV_CODE, 2'b00, PORT_COUNT};
      A_IRQ:   sel = {st.loop_irq, st.cps_irq, st.cps, 5'b00000};
      default: sel = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= acc_valid && !acc_write;
      if (acc_valid && !acc_write) rsp_data <= sel;
    end
  end

  assert_read_answers_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !acc_write |=> rsp_valid);
  assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && !acc_write) |=> !rsp_valid);
endmodule

// File: rtl/sbphy_regbank.sv
module sbphy_regbank
  import sbphy_regbank_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [5:0] GAP_RESET = 6'h3F,
  parameter logic [5:0] ID_RESET  = 6'h09
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [7:0]        acc_wdata,
  output logic              rsp_valid,
  output logic [7:0]        rsp_data,
  input  logic              bus_rst,
  input  logic              selfid_done,
  input  logic [5:0]        selfid_addr,
  input  logic              root_evt,
  input  logic              loop_timeout,
  input  logic              cps_in,
  input  logic              cable_conn,
  input  logic [1:0]        line_a,
  input  logic [1:0]        line_b,
  input  logic              phycfg_load,
  input  logic [5:0]        phycfg_gap,
  output logic [5:0]        gap_count,
  output logic              root_holdoff,
  output logic              start_bus_reset
);
  localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(REG_CFG);
  localparam logic [ADDR_W-1:0] A_IRQ = ADDR_W'(REG_IRQ);

  cfg_t  cfg_q;
  stat_t st_q;
  logic  wr_cfg, wr_irq;

  assign wr_cfg = acc_valid && acc_write && (acc_addr == A_CFG);
  assign wr_irq = acc_valid && acc_write && (acc_addr == A_IRQ);

  sbphy_cfg_regs #(.GAP_RESET(GAP_RESET)) u_cfg (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .wr_cfg(wr_cfg),
    .wdata(acc_wdata), .phycfg_load(phycfg_load), .phycfg_gap(phycfg_gap),
    .cfg_q(cfg_q)
  );

  sbphy_stat_regs #(.ID_RESET(ID_RESET)) u_stat (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .selfid_done(selfid_done),
    .selfid_addr(selfid_addr), .root_evt(root_evt), .loop_timeout(loop_timeout),
    .cps_in(cps_in), .cable_conn(cable_conn), .line_in({line_a, line_b}),
    .wr_irq(wr_irq), .wdata_irq(acc_wdata[7:6]), .st_q(st_q)
  );

  sbphy_rd_mux #(.ADDR_W(ADDR_W)) u_mux (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .cfg(cfg_q), .st(st_q),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  assign gap_count       = cfg_q.gap;
  assign root_holdoff    = cfg_q.rhb;
  assign start_bus_reset = cfg_q.ibr;
endmodule

// File: tb/sbphy_regbank_bench.sv
module sbphy_regbank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic clk = 0;
  logic rst_n = 0;
  logic acc_valid = 0, acc_write = 0;
  logic [3:0] acc_addr = 0;
  logic [7:0] acc_wdata = 0;
  logic rsp_valid;
  logic [7:0] rsp_data;
  logic bus_rst = 0, selfid_done = 0, root_evt = 0, loop_timeout = 0;
  logic [5:0] selfid_addr = 0;
  logic cps_in = 1, cable_conn = 0;
  logic [1:0] line_a = 0, line_b = 0;
  logic phycfg_load = 0;
  logic [5:0] phycfg_gap = 0;
  logic [5:0] gap_count;
  logic root_holdoff, start_bus_reset;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sbphy_regbank u_sbphy_regbank (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .bus_rst(bus_rst), .selfid_done(selfid_done),
    .selfid_addr(selfid_addr), .root_evt(root_evt), .loop_timeout(loop_timeout),
    .cps_in(cps_in), .cable_conn(cable_conn), .line_a(line_a), .line_b(line_b),
    .phycfg_load(phycfg_load), .phycfg_gap(phycfg_gap), .gap_count(gap_count),
    .root_holdoff(root_holdoff), .start_bus_reset(start_bus_reset)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // advance to the next falling edge and drop all one-cycle pulses
  task automatic tick();
    @(negedge clk);
    acc_valid = 0; acc_write = 0; bus_rst = 0; selfid_done = 0;
    root_evt = 0; loop_timeout = 0; phycfg_load = 0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
    tick();
    acc_valid = 1; acc_write = 0; acc_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  task automatic wr_set(input logic [3:0] a, input logic [7:0] d);
    acc_valid = 1; acc_write = 1; acc_addr = a; acc_wdata = d;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    tick(); wr_set(a, d);
  endtask

  task automatic brst();
    tick(); bus_rst = 1;
  endtask

  // monitor: compare each response against the scoreboard
  always @(negedge clk) begin
    if (rsp_valid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R2 unexpected response actual=%h expected=none", rsp_data);
      end else begin
        chk(tag_q.pop_front(), rsp_data, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick(); tick();
    chk("R1 gap port", {2'b0, gap_count}, 8'h3F);
    chk("R1 rhb port", {7'b0, root_holdoff}, 8'h00);
    chk("R1 ibr port", {7'b0, start_bus_reset}, 8'h00);
    rd(0, 8'h25, "R1 reg0");
    rd(1, 8'h3F, "R1 reg1");
    rd(2, 8'h08, "R1 reg2");
    rd(3, 8'h43, "R2 ident");
    rd(4, 8'h20, "R1 reg4");
    rd(7, 8'h00, "R2 unused7");
    rd(15, 8'h00, "R2 unused15");
    // R3 link write and packet load
    wr(1, 8'h05);
    rd(1, 8'h05, "R3 write gap");
    tick(); wr_set(1, 8'h07); phycfg_load = 1; phycfg_gap = 6'h12;
    rd(1, 8'h12, "R3 load beats write");
    tick(); chk("R3 gap port", {2'b0, gap_count}, 8'h12);
    // R4 two-reset fallback
    wr(1, 8'h0A);
    brst();
    rd(1, 8'h0A, "R4 one reset keeps");
    brst();
    rd(1, 8'h3F, "R4 second reset default");
    wr(1, 8'h0C);
    brst();
    tick(); phycfg_load = 1; phycfg_gap = 6'h0D;
    brst();
    rd(1, 8'h0D, "R4 load re-arms");
    brst();
    rd(1, 8'h3F, "R4 default again");
    // R5 initiate bus reset
    wr(1, 8'h4A);
    tick(); chk("R5 ibr port", {7'b0, start_bus_reset}, 8'h01);
    rd(1, 8'h4A, "R5 ibr set");
    brst();
    rd(1, 8'h0A, "R5 ibr cleared");
    brst(); wr_set(1, 8'h45);
    rd(1, 8'h3F, "R5 write dropped on reset");
    tick(); chk("R5 ibr port low", {7'b0, start_bus_reset}, 8'h00);
    // R6 root holdoff
    wr(1, 8'hBF);
    brst();
    rd(1, 8'hBF, "R6 rhb survives");
    tick(); chk("R6 rhb port", {7'b0, root_holdoff}, 8'h01);
    // R7 node address
    tick(); selfid_done = 1; selfid_addr = 6'h15;
    rd(0, 8'h55, "R7 selfid");
    brst();
    rd(0, 8'h25, "R7 reset default");
    brst(); selfid_done = 1; selfid_addr = 6'h15;
    rd(0, 8'h25, "R7 reset wins");
    // R8 root
    tick(); root_evt = 1;
    rd(0, 8'h27, "R8 root set");
    brst();
    rd(0, 8'h25, "R8 root cleared");
    // R9 connection
    rd(2, 8'h00, "R9 conn after resets");
    tick(); cable_conn = 1;
    rd(2, 8'h00, "R9 conn holds");
    brst();
    rd(2, 8'h08, "R9 conn sampled");
    // R10 line states
    tick(); line_a = 2'b11; line_b = 2'b01;
    rd(2, 8'hD8, "R10 Z and one");
    tick(); line_a = 2'b10; line_b = 2'b00;
    rd(2, 8'h88, "R10 zero and invalid");
    // R11 cable power interrupt
    tick(); cps_in = 0;
    rd(4, 8'h40, "R11 irq set");
    rd(0, 8'h24, "R11 level low");
    wr(4, 8'h00);
    rd(4, 8'h40, "R11 refires while low");
    tick(); cps_in = 1; wr_set(4, 8'h00);
    rd(4, 8'h20, "R11 cleared");
    wr(4, 8'hC0);
    rd(4, 8'h20, "R11 write one no effect");
    // R12 loop interrupt
    tick(); loop_timeout = 1;
    rd(4, 8'hA0, "R12 loop set");
    tick(); loop_timeout = 1; wr_set(4, 8'h00);
    rd(4, 8'hA0, "R12 set wins");
    wr(4, 8'h40);
    rd(4, 8'h20, "R12 cleared");
    // R2 read-only writes ignored
    wr(3, 8'hFF); wr(0, 8'hFF); wr(2, 8'hFF);
    rd(3, 8'h43, "R2 ident after write");
    rd(0, 8'h25, "R2 reg0 after write");
    rd(2, 8'h88, "R2 reg2 after write");
    rd(9, 8'h00, "R2 unused9");
    // R1 hardware reset mid-run
    wr(1, 8'hC5);
    tick(); line_a = 0; line_b = 0; cable_conn = 0;
    tick(); rst_n = 0;
    tick(); rst_n = 1;
    tick(); tick();
    chk("R1 gap port after reset", {2'b0, gap_count}, 8'h3F);
    chk("R1 ibr port after reset", {7'b0, start_bus_reset}, 8'h00);
    rd(1, 8'h3F, "R1 reg1 after reset");
    rd(2, 8'h08, "R1 conn after reset");
    rd(4, 8'h20, "R1 irqs after reset");
    tick(); tick(); tick();
    n_chk++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R2 missing responses actual=%0d expected=0", exp_q.size());
    end
    finish_run();
  end
endmodule